// File: doc/BRIEF.md
# Dual-Port Inter-Processor Message Box

This block carries 32-bit messages between two processors, called side A and side B, over eight independent one-way channels. Each side owns a simple register port (byte address, write enable, write data, read strobe, read data) and one interrupt line. Every channel holds a four-entry hardware FIFO. The transmitting side pushes by writing the channel's data word, and the receiving side pops by reading the same word.

A shared set of direction bits chooses, for each channel, which side sends. Each side reads and writes these bits in its own view, so "transmit" always means "this side transmits". Each side has an event enable word and an event status word. It addresses its own pair as local and the other side's pair as remote. A sender can therefore watch the peer's receive-pending bit fall, which tells it that the message was consumed. Receive-pending bits are sticky: they cannot be cleared while the channel FIFO still holds data.

Read data is combinational from the current state. A pop, a push or a register write takes effect at the rising clock edge that samples the strobe. Event status bits follow the FIFO state one cycle later.

Top module: `ipc_msgbox`

## Requirements
- R1: After reset all FIFOs are empty, all direction bits, enable words and status words read 0, and both interrupt lines are low.
- R2: Channel n's direction bits sit in the control word at byte offset 4*(n/4). In a side's own view, bit 4+8*(n%4) means "this side transmits" and bit 8*(n%4) means "this side receives". Side B's view is side A's view with the two bits swapped. A channel with both bits set, or with neither, is inactive: it accepts no push, no pop and raises no event.
- R3: A data write (offset 0x180+4n) from the transmitting side appends to a four-entry FIFO. A data read from the receiving side returns the oldest entry and removes it. The count (offset 0x140+4n, bits [2:0]) reads 0 to 4, and the full flag (offset 0x100+4n, bit 0) is 1 exactly when the count is 4.
- R4: A data write from the side that is not the transmitter has no effect, and a push into a full FIFO is dropped.
- R5: A data read from an empty FIFO, or from the side that is not the receiver, returns 0 and leaves the FIFO unchanged.
- R6: The receiving side's status bit 2n is set while channel n's FIFO is non-empty. Writing 1 to it clears it only when the FIFO is empty, and otherwise it stays set, including after the FIFO drains.
- R7: The transmitting side's status bit 2n+1 is set while channel n's FIFO is not full. A write-1 clear while the FIFO is full clears it, and it sets again once space returns.
- R8: Each side addresses its own enable word at 0x60 and its own status word at 0x70, and the other side's enable word at 0x40 and status word at 0x50, for both reads and writes.
- R9: Each interrupt line is high exactly when some bit is set in both that side's enable word and that side's status word.
- R10: Enable words read back as written, and writing 0 to a status bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_addr | input | 12 | Side A byte address |
| a_wr | input | 1 | Side A write enable |
| a_wdata | input | 32 | Side A write data |
| a_rd | input | 1 | Side A read strobe (pops when it addresses a data word) |
| a_rdata | output | 32 | Side A read data, combinational |
| a_irq | output | 1 | Side A interrupt |
| b_addr | input | 12 | Side B byte address |
| b_wr | input | 1 | Side B write enable |
| b_wdata | input | 32 | Side B write data |
| b_rd | input | 1 | Side B read strobe (pops when it addresses a data word) |
| b_rdata | output | 32 | Side B read data, combinational |
| b_irq | output | 1 | Side B interrupt |

## Verification
The sweep runs every channel in both directions, with one side configuring in its own view. This exposes a wrong bit position or a missing swap between the two views. Each pass pushes five words whose values encode the channel, the direction and the sequence number, so the data shows reordering, cross-channel leaks and the dropped fifth push. Each pass also makes writes and reads from the wrong side, pops an empty FIFO, and clears status bits while the FIFO is full, non-empty and empty. These cases separate a status bit that is sticky from one that follows the FIFO level, and a channel that ignores the wrong side from one that accepts any side. Status clears and enables go through both the local and the remote addresses, which shows whether the two sides see the same registers in swapped roles.

// File: rtl/ipc_msgbox_pkg.sv
package ipc_msgbox_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_REN, RG_RST, RG_LEN, RG_LST, RG_FULL, RG_CNT, RG_DATA
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [3:0] idx;
  } reg_sel_t;

  // control word that holds channel n
  function automatic int ctl_word(input int n);
    return n / 4;
  endfunction

  // own-view "this side receives" bit of channel n
  function automatic int ctl_rx_pos(input int n);
    return 8 * (n % 4);
  endfunction

  // own-view "this side transmits" bit of channel n
  function automatic int ctl_tx_pos(input int n);
    return 8 * (n % 4) + 4;
  endfunction

  function automatic int evt_rx_pos(input int n);
    return 2 * n;
  endfunction

  function automatic int evt_tx_pos(input int n);
    return 2 * n + 1;
  endfunction

  function automatic reg_sel_t decode_addr(input logic [15:0] a, input int nch);
    reg_sel_t r;
    r.kind = RG_NONE;
    r.idx  = a[5:2];
    if (a[1:0] == 2'b00) begin
      case (a[15:6])
        10'h000: if (int'(a[5:2]) < (nch + 3) / 4) r.kind = RG_CTRL;
        10'h001: begin
          case (a[5:2])
            4'h0:    r.kind = RG_REN;
            4'h4:    r.kind = RG_RST;
            4'h8:    r.kind = RG_LEN;
            4'hC:    r.kind = RG_LST;
            default: r.kind = RG_NONE;
          endcase
        end
        10'h004: if (int'(a[5:2]) < nch) r.kind = RG_FULL;
        10'h005: if (int'(a[5:2]) < nch) r.kind = RG_CNT;
        10'h006: if (int'(a[5:2]) < nch) r.kind = RG_DATA;
        default: r.kind = RG_NONE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/ipc_msgbox_fifo.sv
module ipc_msgbox_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= ptr_inc(wp);
      if (pop_ok)  rp <= ptr_inc(rp);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

endmodule

// File: rtl/ipc_msgbox_evt.sv
module ipc_msgbox_evt #(
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          own_en_we,
  input  logic [EW-1:0] own_en_wd,
  input  logic          peer_en_we,
  input  logic [EW-1:0] peer_en_wd,
  input  logic [EW-1:0] own_clr,
  input  logic [EW-1:0] peer_clr,
  input  logic [EW-1:0] set_v,
  output logic [EW-1:0] en,
  output logic [EW-1:0] st,
  output logic          irq
);
  logic [EW-1:0] clr_all;

  assign clr_all = own_clr | peer_clr;
  assign irq     = |(en & st);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= '0;
      st <= '0;
    end else begin
      if (own_en_we)       en <= own_en_wd;
      else if (peer_en_we) en <= peer_en_wd;
      // a live condition wins over a clear in the same cycle
      st <= set_v | (st & ~clr_all);
    end
  end

endmodule

// File: rtl/ipc_msgbox_port.sv
module ipc_msgbox_port
  import ipc_msgbox_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int DW   = 32,
  parameter int AW   = 12,
  parameter int CW   = 3,
  parameter int EW   = 16,
  parameter int SIDE = 0
) (
  input  logic                   clk,
  input  logic [AW-1:0]          addr,
  input  logic                   wr,
  input  logic [DW-1:0]          wdata,
  input  logic                   rd,
  output logic [DW-1:0]          rdata,
  input  logic [NCH-1:0]         atx,
  input  logic [NCH-1:0]         arx,
  input  logic [EW-1:0]          en_loc,
  input  logic [EW-1:0]          st_loc,
  input  logic [EW-1:0]          en_rem,
  input  logic [EW-1:0]          st_rem,
  input  logic [NCH-1:0]         full,
  input  logic [NCH-1:0][CW-1:0] cnt,
  input  logic [NCH-1:0][DW-1:0] head,
  input  logic [NCH-1:0]         can_pop,
  output logic [NCH-1:0]         ctl_we,
  output logic [NCH-1:0]         ctl_atx,
  output logic [NCH-1:0]         ctl_arx,
  output logic                   en_loc_we,
  output logic                   en_rem_we,
  output logic [EW-1:0]          en_wd,
  output logic [EW-1:0]          st_loc_clr,
  output logic [EW-1:0]          st_rem_clr,
  output logic [NCH-1:0]         data_we,
  output logic [NCH-1:0]         data_re,
  output logic [DW-1:0]          push_data
);
  reg_sel_t       sel;
  logic [NCH-1:0] my_tx, my_rx, wr_tx, wr_rx;
  logic           unused_clk;

  assign unused_clk = clk;
  assign sel        = decode_addr(16'(addr), NCH);
  assign push_data  = wdata;
  assign en_wd      = wdata[EW-1:0];

  // side A sees the stored bits as-is, side B sees them swapped
  generate
    if (SIDE == 0) begin : g_view_a
      assign my_tx   = atx;
      assign my_rx   = arx;
      assign ctl_atx = wr_tx;
      assign ctl_arx = wr_rx;
    end else begin : g_view_b
      assign my_tx   = arx;
      assign my_rx   = atx;
      assign ctl_atx = wr_rx;
      assign ctl_arx = wr_tx;
    end
  endgenerate

  always_comb begin
    en_loc_we  = wr && (sel.kind == RG_LEN);
    en_rem_we  = wr && (sel.kind == RG_REN);
    st_loc_clr = (wr && sel.kind == RG_LST) ? wdata[EW-1:0] : '0;
    st_rem_clr = (wr && sel.kind == RG_RST) ? wdata[EW-1:0] : '0;
    for (int n = 0; n < NCH; n++) begin
      wr_tx[n]   = wdata[ctl_tx_pos(n)];
      wr_rx[n]   = wdata[ctl_rx_pos(n)];
      ctl_we[n]  = wr && (sel.kind == RG_CTRL) && (sel.idx == 4'(ctl_word(n)));
      data_we[n] = wr && (sel.kind == RG_DATA) && (sel.idx == 4'(n));
      data_re[n] = rd && (sel.kind == RG_DATA) && (sel.idx == 4'(n));
    end
  end

  always_comb begin
    rdata = '0;
    case (sel.kind)
      RG_CTRL: begin
        for (int n = 0; n < NCH; n++) begin
          if (sel.idx == 4'(ctl_word(n))) begin
            rdata[ctl_rx_pos(n)] = my_rx[n];
            rdata[ctl_tx_pos(n)] = my_tx[n];
          end
        end
      end
      RG_REN: rdata = DW'(en_rem);
      RG_RST: rdata = DW'(st_rem);
      RG_LEN: rdata = DW'(en_loc);
      RG_LST: rdata = DW'(st_loc);
      RG_FULL: begin
        for (int n = 0; n < NCH; n++)
          if (sel.idx == 4'(n)) rdata[0] = full[n];
      end
      RG_CNT: begin
        for (int n = 0; n < NCH; n++)
          if (sel.idx == 4'(n)) rdata = DW'(cnt[n]);
      end
      RG_DATA: begin
        for (int n = 0; n < NCH; n++)
          if (sel.idx == 4'(n) && can_pop[n]) rdata = head[n];
      end
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/ipc_msgbox.sv
module ipc_msgbox
  import ipc_msgbox_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_addr,
  input  logic          a_wr,
  input  logic [DW-1:0] a_wdata,
  input  logic          a_rd,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic [AW-1:0] b_addr,
  input  logic          b_wr,
  input  logic [DW-1:0] b_wdata,
  input  logic          b_rd,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  localparam int EW = 2 * NCH;
  localparam int CW = $clog2(DEPTH + 1);

  // per-side bus view
  logic [1:0][AW-1:0] p_addr;
  logic [1:0]         p_wr, p_rd;
  logic [1:0][DW-1:0] p_wdata, p_rdata, p_push_data;

  // per-side decoded strobes
  logic [1:0][NCH-1:0] p_ctl_we, p_ctl_atx, p_ctl_arx;
  logic [1:0][NCH-1:0] p_data_we, p_data_re, p_can_pop;
  logic [1:0]          p_en_loc_we, p_en_rem_we;
  logic [1:0][EW-1:0]  p_en_wd, p_st_loc_clr, p_st_rem_clr;

  // event registers per side
  logic [1:0][EW-1:0]  en_v, st_v, set_v;
  logic [1:0]          irq_v;

  // channel state; direction stored in side A's view
  logic [NCH-1:0]         ctl_atx, ctl_arx;
  logic [NCH-1:0]         chan_active, chan_txb;
  logic [NCH-1:0]         chan_push, chan_pop, chan_full, chan_empty;
  logic [NCH-1:0][CW-1:0] chan_cnt;
  logic [NCH-1:0][DW-1:0] chan_head;

  assign p_addr  = {b_addr, a_addr};
  assign p_wr    = {b_wr, a_wr};
  assign p_rd    = {b_rd, a_rd};
  assign p_wdata = {b_wdata, a_wdata};
  assign a_rdata = p_rdata[0];
  assign b_rdata = p_rdata[1];
  assign a_irq   = irq_v[0];
  assign b_irq   = irq_v[1];

  assign chan_active = ctl_atx ^ ctl_arx;
  assign chan_txb    = ctl_arx;   // 1: side B transmits

  generate
    for (genvar s = 0; s < 2; s++) begin : g_side
      ipc_msgbox_port #(
        .NCH(NCH), .DW(DW), .AW(AW), .CW(CW), .EW(EW), .SIDE(s)
      ) u_port (
        .clk       (clk),
        .addr      (p_addr[s]),
        .wr        (p_wr[s]),
        .wdata     (p_wdata[s]),
        .rd        (p_rd[s]),
        .rdata     (p_rdata[s]),
        .atx       (ctl_atx),
        .arx       (ctl_arx),
        .en_loc    (en_v[s]),
        .st_loc    (st_v[s]),
        .en_rem    (en_v[1-s]),
        .st_rem    (st_v[1-s]),
        .full      (chan_full),
        .cnt       (chan_cnt),
        .head      (chan_head),
        .can_pop   (p_can_pop[s]),
        .ctl_we    (p_ctl_we[s]),
        .ctl_atx   (p_ctl_atx[s]),
        .ctl_arx   (p_ctl_arx[s]),
        .en_loc_we (p_en_loc_we[s]),
        .en_rem_we (p_en_rem_we[s]),
        .en_wd     (p_en_wd[s]),
        .st_loc_clr(p_st_loc_clr[s]),
        .st_rem_clr(p_st_rem_clr[s]),
        .data_we   (p_data_we[s]),
        .data_re   (p_data_re[s]),
        .push_data (p_push_data[s])
      );

      ipc_msgbox_evt #(.EW(EW)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_en_we (p_en_loc_we[s]),
        .own_en_wd (p_en_wd[s]),
        .peer_en_we(p_en_rem_we[1-s]),
        .peer_en_wd(p_en_wd[1-s]),
        .own_clr   (p_st_loc_clr[s]),
        .peer_clr  (p_st_rem_clr[1-s]),
        .set_v     (set_v[s]),
        .en        (en_v[s]),
        .st        (st_v[s]),
        .irq       (irq_v[s])
      );
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chan
      ipc_msgbox_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (chan_push[n]),
        .pop  (chan_pop[n]),
        .wdata(chan_txb[n] ? p_push_data[1] : p_push_data[0]),
        .head (chan_head[n]),
        .count(chan_cnt[n]),
        .full (chan_full[n]),
        .empty(chan_empty[n])
      );
    end
  endgenerate

  always_comb begin
    set_v = '0;
    for (int n = 0; n < NCH; n++) begin
      chan_push[n]    = chan_active[n] &
                        (chan_txb[n] ? p_data_we[1][n] : p_data_we[0][n]);
      chan_pop[n]     = chan_active[n] &
                        (chan_txb[n] ? p_data_re[0][n] : p_data_re[1][n]);
      p_can_pop[0][n] = chan_active[n] &  chan_txb[n] & ~chan_empty[n];
      p_can_pop[1][n] = chan_active[n] & ~chan_txb[n] & ~chan_empty[n];
      set_v[0][evt_rx_pos(n)] = p_can_pop[0][n];
      set_v[1][evt_rx_pos(n)] = p_can_pop[1][n];
      set_v[0][evt_tx_pos(n)] = chan_active[n] & ~chan_txb[n] & ~chan_full[n];
      set_v[1][evt_tx_pos(n)] = chan_active[n] &  chan_txb[n] & ~chan_full[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_atx <= '0;
      ctl_arx <= '0;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        if (p_ctl_we[0][n]) begin
          ctl_atx[n] <= p_ctl_atx[0][n];
          ctl_arx[n] <= p_ctl_arx[0][n];
        end else if (p_ctl_we[1][n]) begin
          ctl_atx[n] <= p_ctl_atx[1][n];
          ctl_arx[n] <= p_ctl_arx[1][n];
        end
      end
    end
  end

endmodule

// File: rtl/ipc_msgbox_chk.sv
module ipc_msgbox_chk #(
  parameter int NCH   = 8,
  parameter int DEPTH = 4,
  parameter int CW    = 3,
  parameter int EW    = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         push,
  input logic [NCH-1:0]         pop,
  input logic [NCH-1:0]         active,
  input logic [NCH-1:0]         txb,
  input logic [NCH-1:0][CW-1:0] cnt,
  input logic [1:0][EW-1:0]     st
);
  generate
    for (genvar n = 0; n < NCH; n++) begin : g_chk
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt[n]) <= DEPTH) else $error("count overflow ch%0d", n); // R3

      AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(cnt[n]) == int'($past(cnt[n])) ||
                  int'(cnt[n]) == int'($past(cnt[n])) + 1 ||
                  int'(cnt[n]) + 1 == int'($past(cnt[n]))))
        else $error("count jump ch%0d", n); // R3

      AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push[n] && !pop[n] && int'(cnt[n]) == DEPTH) |=> int'(cnt[n]) == DEPTH)
        else $error("push into full ch%0d", n); // R4

      AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop[n] && !push[n] && cnt[n] == '0) |=> cnt[n] == '0)
        else $error("pop from empty ch%0d", n); // R5

      AST_RX_PEND_A: assert property (@(posedge clk) disable iff (!rst_n)
        (active[n] && txb[n] && cnt[n] != '0) |=> st[0][2*n])
        else $error("side A rx pending missing ch%0d", n); // R6

      AST_RX_PEND_B: assert property (@(posedge clk) disable iff (!rst_n)
        (active[n] && !txb[n] && cnt[n] != '0) |=> st[1][2*n])
        else $error("side B rx pending missing ch%0d", n); // R6

      AST_TX_READY_A: assert property (@(posedge clk) disable iff (!rst_n)
        (active[n] && !txb[n] && int'(cnt[n]) < DEPTH) |=> st[0][2*n+1])
        else $error("side A tx ready missing ch%0d", n); // R7

      AST_TX_READY_B: assert property (@(posedge clk) disable iff (!rst_n)
        (active[n] && txb[n] && int'(cnt[n]) < DEPTH) |=> st[1][2*n+1])
        else $error("side B tx ready missing ch%0d", n); // R7
    end
  endgenerate

endmodule

bind ipc_msgbox ipc_msgbox_chk #(
  .NCH(NCH), .DEPTH(DEPTH), .CW(CW), .EW(EW)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .push  (chan_push),
  .pop   (chan_pop),
  .active(chan_active),
  .txb   (chan_txb),
  .cnt   (chan_cnt),
  .st    (st_v)
);

// File: tb/test_ipc_msgbox.sv
`timescale 1ns/1ps
module test_ipc_msgbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] a_addr = '0, b_addr = '0;
  logic        a_wr = 1'b0, b_wr = 1'b0, a_rd = 1'b0, b_rd = 1'b0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  wire  [31:0] a_rdata, b_rdata;
  wire         a_irq, b_irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  ipc_msgbox i_ipc_msgbox (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_wr(a_wr), .a_wdata(a_wdata), .a_rd(a_rd),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_addr(b_addr), .b_wr(b_wr), .b_wdata(b_wdata), .b_rd(b_rd),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  localparam logic [11:0] EN_REM = 12'h040, ST_REM = 12'h050;
  localparam logic [11:0] EN_LOC = 12'h060, ST_LOC = 12'h070;

  function automatic logic [11:0] full_addr(input int n); return 12'(256 + 4*n); endfunction
  function automatic logic [11:0] cnt_addr(input int n);  return 12'(320 + 4*n); endfunction
  function automatic logic [11:0] data_addr(input int n); return 12'(384 + 4*n); endfunction
  function automatic logic [11:0] ctl_addr(input int n);  return 12'(4*(n/4)); endfunction
  // own-view control value: rx at 8*(n%4), tx at 8*(n%4)+4
  function automatic logic [31:0] view_val(input int n, input int rx, input int tx);
    return (32'(rx) << (8*(n%4))) | (32'(tx) << (8*(n%4)+4));
  endfunction
  function automatic logic [31:0] word_of(input int n, input int d, input int k);
    return 32'hC0DE_0000 + 32'(n*256 + d*16 + k);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int s, input logic [11:0] ad, input logic [31:0] d);
    @(negedge clk);
    if (s == 0) begin a_addr = ad; a_wdata = d; a_wr = 1'b1; end
    else        begin b_addr = ad; b_wdata = d; b_wr = 1'b1; end
    @(negedge clk);
    a_wr = 1'b0; b_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_rd(input int s, input logic [11:0] ad, output logic [31:0] d);
    @(negedge clk);
    if (s == 0) begin a_addr = ad; a_rd = 1'b1; end
    else        begin b_addr = ad; b_rd = 1'b1; end
    #1 d = (s == 0) ? a_rdata : b_rdata;
    @(negedge clk);
    a_rd = 1'b0; b_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input int s, input logic [11:0] ad,
                        input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(s, ad, v);
    check(req, v, exp);
  endtask

  function automatic logic [31:0] irq_of(input int s);
    return (s == 0) ? 32'(a_irq) : 32'(b_irq);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int t, r;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_chk("R1 ctrl A", 0, 12'h000, 32'h0);
    rd_chk("R1 ctrl B", 1, 12'h004, 32'h0);
    rd_chk("R1 status A", 0, ST_LOC, 32'h0);
    rd_chk("R1 status B", 1, ST_LOC, 32'h0);
    rd_chk("R1 enable A", 0, EN_LOC, 32'h0);
    rd_chk("R1 count ch7", 1, cnt_addr(7), 32'h0);
    check("R1 irq A", 32'(a_irq), 32'h0);
    check("R1 irq B", 32'(b_irq), 32'h0);

    // R2: both direction bits set means inactive
    bus_wr(0, 12'h000, view_val(0, 1, 1));
    bus_wr(0, data_addr(0), 32'h1111_1111);
    bus_wr(1, data_addr(0), 32'h2222_2222);
    rd_chk("R2 inactive count", 0, cnt_addr(0), 32'h0);
    rd_chk("R2 inactive status A", 0, ST_LOC, 32'h0);
    rd_chk("R2 inactive status B", 1, ST_LOC, 32'h0);
    bus_wr(0, 12'h000, 32'h0);

    for (int n = 0; n < 8; n++) begin
      for (int d = 0; d < 2; d++) begin
        t = d;
        r = 1 - d;
        // the transmitter configures in its own view
        bus_wr(t, ctl_addr(n), view_val(n, 0, 1));
        rd_chk("R2 view tx side", t, ctl_addr(n), view_val(n, 0, 1));
        rd_chk("R2 view rx side", r, ctl_addr(n), view_val(n, 1, 0));
        rd_chk("R7 tx ready", t, ST_LOC, 32'(1) << (2*n+1));
        rd_chk("R8 remote status", r, ST_REM, 32'(1) << (2*n+1));

        bus_wr(r, EN_LOC, 32'(1) << (2*n));
        rd_chk("R10 enable readback", r, EN_LOC, 32'(1) << (2*n));
        rd_chk("R8 remote enable", t, EN_REM, 32'(1) << (2*n));
        check("R9 irq idle", irq_of(r), 32'h0);

        bus_wr(r, data_addr(n), 32'hBAD0_0000);
        rd_chk("R4 wrong side write", t, cnt_addr(n), 32'h0);

        for (int k = 0; k < 5; k++) begin
          bus_wr(t, data_addr(n), word_of(n, d, k));
          rd_chk("R3 R4 count after push", r, cnt_addr(n), 32'((k < 4) ? k + 1 : 4));
        end
        rd_chk("R3 full flag", t, full_addr(n), 32'h1);
        rd_chk("R6 rx pending", r, ST_LOC, 32'(1) << (2*n));
        check("R9 irq rx side", irq_of(r), 32'h1);
        check("R9 irq tx side", irq_of(t), 32'h0);

        bus_wr(t, ST_LOC, 32'(1) << (2*n+1));
        rd_chk("R7 clear while full", t, ST_LOC, 32'h0);
        bus_wr(r, ST_LOC, 32'(1) << (2*n));
        rd_chk("R6 clear refused", r, ST_LOC, 32'(1) << (2*n));
        bus_wr(r, ST_LOC, 32'h0);
        rd_chk("R10 write zero", r, ST_LOC, 32'(1) << (2*n));

        rd_chk("R5 wrong side read", t, data_addr(n), 32'h0);
        rd_chk("R5 count kept", r, cnt_addr(n), 32'h4);

        for (int k = 0; k < 4; k++) begin
          rd_chk("R3 pop order", r, data_addr(n), word_of(n, d, k));
          rd_chk("R3 count after pop", t, cnt_addr(n), 32'(3 - k));
          if (k == 0) rd_chk("R7 ready again", t, ST_LOC, 32'(1) << (2*n+1));
        end
        rd_chk("R5 empty pop", r, data_addr(n), 32'h0);
        rd_chk("R5 empty count", r, cnt_addr(n), 32'h0);
        rd_chk("R3 not full", r, full_addr(n), 32'h0);
        rd_chk("R6 sticky after drain", r, ST_LOC, 32'(1) << (2*n));
        check("R9 irq sticky", irq_of(r), 32'h1);

        if (d == 0) bus_wr(r, ST_LOC, 32'(1) << (2*n));
        else        bus_wr(t, ST_REM, 32'(1) << (2*n));
        rd_chk("R6 R8 clear when empty", r, ST_LOC, 32'h0);
        check("R9 irq cleared", irq_of(r), 32'h0);

        bus_wr(0, ctl_addr(n), 32'h0);
        bus_wr(0, ST_LOC, 32'hFFFF);
        bus_wr(1, ST_LOC, 32'hFFFF);
        bus_wr(r, EN_LOC, 32'h0);
        rd_chk("R7 cleanup tx side", t, ST_LOC, 32'h0);
      end
    end

    summary();
    $finish;
  end

endmodule